// File: doc/BRIEF.md
# Multi-Hit Pulse Edge Extractor

This block handles one detector channel whose input has already been cut into equal time bins (one bin is 1.2 ns). A parallel word of `WORD` consecutive bins arrives on each clock. Inside an event window, the block finds each high pulse. It reports the pulse's start as the circular bin address of its rising transition. It reports the pulse's width as the distance in bins from that rising transition to the falling transition. The qualified hits go into a small per-event record list, which is read back through a select input.

An event opens with a start pulse that carries the bin address of the first sample. Sample words then follow, and the final word is flagged. The block applies the qualification rules as it goes:

- A pulse that stays high for fewer than `MIN_W` bins is dropped.
- Pulses separated by fewer than `MIN_GAP` low bins are joined into one hit.
- At most `MAX_HITS` records are kept.

One clock after the final word, a done flag rises and the record count becomes valid.

Top module: `hx_pulse_extract`

## Requirements
- R1: Bit i of the word with sequence number k in a window whose start address is B is the sample at bin address B + WORD·k + i. A hit's time field is the bin address of its first high sample, where the sample before the window counts as low.
- R2: A hit's width field is the address of the first low bin after the pulse minus the hit's time field, taken modulo 2^ADDR_W.
- R3: Transitions are found at any bin position, including between bit WORD-1 of one word and bit 0 of the next. A pulse that is high in the window's first bin has time equal to the window start address.
- R4: A high stretch shorter than MIN_W bins (default 4), with no other high bins within MIN_GAP, makes no record and does not advance the count.
- R5: High stretches separated by fewer than MIN_GAP low bins (default 4) form one hit. That hit starts at the first rising transition and ends at the last falling transition. The joined hit is kept when its total span is at least MIN_W. A gap of MIN_GAP or more low bins separates two hits.
- R6: At most MAX_HITS (default 7) records are stored per event, in time order. Qualified pulses after that are dropped and the count stays at MAX_HITS.
- R7: A hit still high after the last bin of the final word is recorded with width equal to (address just past the last bin) minus its time, and its truncation bit is 1. A hit whose closing gap is cut short by the window end is recorded normally, with truncation bit 0.
- R8: `evt_done` goes to 1 on the clock edge that takes the final word and holds until the next `evt_start`. `hit_cnt` holds the event's record count while `evt_done` is 1.
- R9: `evt_start` clears the count, the done flag, the records and the scan state. Sample words that arrive while no window is open change nothing.
- R10: For rd_sel = j < hit_cnt, the read port shows record j combinationally. `rd_idx` equals j.
- R11: Bin addresses and widths wrap modulo 2^ADDR_W (default 4096), so a pulse that crosses address 0 has the correct time and width.
- R12: After reset, `evt_done` is 0 and `hit_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| evt_start | input | 1 | Opens an event window and clears previous results |
| evt_base | input | ADDR_W | Bin address of the first sample of the window |
| smp_vld | input | 1 | A sample word is present |
| smp_last | input | 1 | This word is the last of the window |
| smp_data | input | WORD | Consecutive samples; bit 0 is the earliest |
| rd_sel | input | IW | Record number to read |
| rd_time | output | ADDR_W | Time (rising bin address) of the selected record |
| rd_width | output | ADDR_W | Width in bins of the selected record |
| rd_trunc | output | 1 | Selected record was cut off by the window end |
| rd_idx | output | IW | Hit index stored with the selected record |
| hit_cnt | output | CW | Number of records stored in the event |
| evt_done | output | 1 | Window closed; results valid |

## Verification
The hardest state to reach from the ports is a hit candidate that is still open when a word boundary or the window end arrives. This is a pulse sitting in its closing gap, or a chain of spikes that joins across several words. The stimulus builds each event from explicit runs of high and low bins with lengths next to MIN_W and MIN_GAP (3 versus 4). Those runs straddle word edges, address 0 and the window end. A behavioural model groups the runs over the whole event and predicts the record list and the done flag on every clock.

// File: rtl/hx_pkg.sv
package hx_pkg;

   // Level state of the per-channel scanner
   typedef enum logic [1:0] {
      LV_IDLE = 2'd0,   // low, no hit candidate open
      LV_HIGH = 2'd1,   // inside a high stretch
      LV_GAP  = 2'd2    // low, candidate may still be joined
   } lvl_e;

   // Bits needed to count 0..n
   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/hx_addr_track.sv
module hx_addr_track #(
   parameter int WORD   = 8,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              adv,
   output logic [ADDR_W-1:0] word_addr
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_addr <= '0;
      else if (load)
         word_addr <= base;
      else if (adv)
         word_addr <= word_addr + STEP;
   end

   // R11: consecutive words are WORD bins apart, modulo the ring length
   a_r11_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=> (word_addr == $past(word_addr) + STEP));

   // R1: a load places the window start exactly
   a_r1_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (word_addr == $past(base)));

endmodule

// File: rtl/hx_edge_scan.sv
module hx_edge_scan
   import hx_pkg::*;
#(
   parameter int WORD    = 8,
   parameter int ADDR_W  = 12,
   parameter int MIN_W   = 4,
   parameter int MIN_GAP = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        step,
   input  logic                        last,
   input  logic [WORD-1:0]             data,
   input  logic [ADDR_W-1:0]           base_addr,
   output logic [WORD:0]               em_vld,
   output logic [WORD:0][ADDR_W-1:0]   em_time,
   output logic [WORD:0][ADDR_W-1:0]   em_width,
   output logic [WORD:0]               em_trunc
);

   localparam int NS = WORD + 1;
   localparam int GW = cnt_bits(MIN_GAP);
   localparam logic [ADDR_W-1:0] WMIN = ADDR_W'(MIN_W);
   localparam logic [GW-1:0]     GMAX = GW'(MIN_GAP);

   lvl_e              lvl_q, lvl_n;
   logic [ADDR_W-1:0] rise_q, rise_n, fall_q, fall_n;
   logic [GW-1:0]     gap_q, gap_n;

   logic [NS-1:0]             ev;
   logic [NS-1:0][ADDR_W-1:0] et, ew;
   logic [NS-1:0]             etr;
   logic [ADDR_W-1:0]         bin_a, span, end_a;

   // Unrolled walk over the bins of one word, earliest first
   always_comb begin
      lvl_n  = lvl_q;
      rise_n = rise_q;
      fall_n = fall_q;
      gap_n  = gap_q;
      ev     = '0;
      et     = '0;
      ew     = '0;
      etr    = '0;
      bin_a  = base_addr;
      span   = '0;
      end_a  = base_addr + ADDR_W'(WORD);
      for (int i = 0; i < WORD; i++) begin
         bin_a = base_addr + ADDR_W'(i);
         case (lvl_n)
            LV_IDLE: begin
               if (data[i]) begin
                  lvl_n  = LV_HIGH;
                  rise_n = bin_a;
               end
            end
            LV_HIGH: begin
               if (!data[i]) begin
                  lvl_n  = LV_GAP;
                  fall_n = bin_a;
                  gap_n  = GW'(1);
               end
            end
            default: begin
               if (data[i]) begin
                  lvl_n = LV_HIGH;          // join: keep the first rise
               end else begin
                  gap_n = gap_n + GW'(1);
                  if (gap_n == GMAX) begin
                     lvl_n = LV_IDLE;
                     span  = fall_n - rise_n;
                     if (span >= WMIN) begin
                        ev[i] = 1'b1;
                        et[i] = rise_n;
                        ew[i] = span;
                     end
                  end
               end
            end
         endcase
      end
      // Window end: close whatever is still open in the extra slot
      if (last) begin
         if (lvl_n == LV_HIGH) begin
            span = end_a - rise_n;
            if (span >= WMIN) begin
               ev[WORD]  = 1'b1;
               et[WORD]  = rise_n;
               ew[WORD]  = span;
               etr[WORD] = 1'b1;
            end
         end else if (lvl_n == LV_GAP) begin
            span = fall_n - rise_n;
            if (span >= WMIN) begin
               ev[WORD] = 1'b1;
               et[WORD] = rise_n;
               ew[WORD] = span;
            end
         end
         lvl_n = LV_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= LV_IDLE;
         rise_q <= '0;
         fall_q <= '0;
         gap_q  <= '0;
      end else if (clr) begin
         lvl_q  <= LV_IDLE;
         rise_q <= '0;
         fall_q <= '0;
         gap_q  <= '0;
      end else if (step) begin
         lvl_q  <= lvl_n;
         rise_q <= rise_n;
         fall_q <= fall_n;
         gap_q  <= gap_n;
      end
   end

   // One emission slot per bin plus the window-end slot
   for (genvar k = 0; k < NS; k++) begin : g_slot
      assign em_vld[k]   = step & ev[k];
      assign em_time[k]  = et[k];
      assign em_width[k] = ew[k];
      assign em_trunc[k] = step & etr[k];
   end

   // R5: an open gap is always shorter than the separation limit
   a_r5_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q == LV_GAP) |-> (gap_q < GMAX));

   // R7: after the final word the scanner is idle
   a_r7_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last && !clr) |=> (lvl_q == LV_IDLE));

   // R9: clearing returns the scanner to idle
   a_r9_scan_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (lvl_q == LV_IDLE));

endmodule

// File: rtl/hx_hit_store.sv
module hx_hit_store
   import hx_pkg::*;
#(
   parameter int NS       = 9,
   parameter int ADDR_W   = 12,
   parameter int MAX_HITS = 7,
   parameter int MIN_W    = 4,
   parameter int IW       = 3,
   parameter int CW       = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic [NS-1:0]             em_vld,
   input  logic [NS-1:0][ADDR_W-1:0] em_time,
   input  logic [NS-1:0][ADDR_W-1:0] em_width,
   input  logic [NS-1:0]             em_trunc,
   input  logic [IW-1:0]             rd_sel,
   output logic [CW-1:0]             hit_cnt,
   output logic [ADDR_W-1:0]         rd_time,
   output logic [ADDR_W-1:0]         rd_width,
   output logic                      rd_trunc,
   output logic [IW-1:0]             rd_idx
);

   localparam logic [CW-1:0] CAP = CW'(MAX_HITS);

   logic [CW-1:0]                   cnt_q, cnt_n;
   logic [MAX_HITS-1:0][ADDR_W-1:0] t_q, t_n, w_q, w_n;
   logic [MAX_HITS-1:0]             tr_q, tr_n;
   logic [MAX_HITS-1:0][IW-1:0]     ix_q, ix_n;

   // Append emissions in slot order until the list is full
   always_comb begin
      cnt_n = cnt_q;
      t_n   = t_q;
      w_n   = w_q;
      tr_n  = tr_q;
      ix_n  = ix_q;
      for (int k = 0; k < NS; k++) begin
         if (em_vld[k] && (cnt_n < CAP)) begin
            for (int j = 0; j < MAX_HITS; j++) begin
               if (cnt_n == CW'(j)) begin
                  t_n[j]  = em_time[k];
                  w_n[j]  = em_width[k];
                  tr_n[j] = em_trunc[k];
                  ix_n[j] = IW'(j);
               end
            end
            cnt_n = cnt_n + CW'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         t_q   <= '0;
         w_q   <= '0;
         tr_q  <= '0;
         ix_q  <= '0;
      end else if (clr) begin
         cnt_q <= '0;
         t_q   <= '0;
         w_q   <= '0;
         tr_q  <= '0;
         ix_q  <= '0;
      end else begin
         cnt_q <= cnt_n;
         t_q   <= t_n;
         w_q   <= w_n;
         tr_q  <= tr_n;
         ix_q  <= ix_n;
      end
   end

   assign hit_cnt = cnt_q;

   // Read port: plain select, zeros outside the list
   always_comb begin
      rd_time  = '0;
      rd_width = '0;
      rd_trunc = 1'b0;
      rd_idx   = '0;
      for (int j = 0; j < MAX_HITS; j++) begin
         if (rd_sel == IW'(j)) begin
            rd_time  = t_q[j];
            rd_width = w_q[j];
            rd_trunc = tr_q[j];
            rd_idx   = ix_q[j];
         end
      end
   end

   // R6: the count never passes the cap
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CAP);

   // R6: without a clear the count never falls
   a_r6_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt_q >= $past(cnt_q)));

   // R4: every stored, untruncated record meets the minimum width
   a_r4_min_width: assert property (@(posedge clk) disable iff (!rst_n)
      ((CW'(rd_sel) < cnt_q) && !rd_trunc) |-> (rd_width >= ADDR_W'(MIN_W)));

   // R10: a stored record carries its own position as index
   a_r10_index: assert property (@(posedge clk) disable iff (!rst_n)
      (CW'(rd_sel) < cnt_q) |-> (rd_idx == rd_sel));

endmodule

// File: rtl/hx_pulse_extract.sv
module hx_pulse_extract
   import hx_pkg::*;
#(
   parameter int WORD     = 8,
   parameter int ADDR_W   = 12,
   parameter int MIN_W    = 4,
   parameter int MIN_GAP  = 4,
   parameter int MAX_HITS = 7,
   parameter int IW       = (MAX_HITS > 1) ? $clog2(MAX_HITS) : 1,
   parameter int CW       = cnt_bits(MAX_HITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_start,
   input  logic [ADDR_W-1:0] evt_base,
   input  logic              smp_vld,
   input  logic              smp_last,
   input  logic [WORD-1:0]   smp_data,
   input  logic [IW-1:0]     rd_sel,
   output logic [ADDR_W-1:0] rd_time,
   output logic [ADDR_W-1:0] rd_width,
   output logic              rd_trunc,
   output logic [IW-1:0]     rd_idx,
   output logic [CW-1:0]     hit_cnt,
   output logic              evt_done
);

   localparam int NS = WORD + 1;

   // Elaboration-time parameter checks
   if (WORD < 1)               begin : g_bad_word  $error("WORD must be at least 1");        end
   if (MIN_W < 1)              begin : g_bad_minw  $error("MIN_W must be at least 1");       end
   if (MIN_GAP < 2)            begin : g_bad_gap   $error("MIN_GAP must be at least 2");     end
   if (MAX_HITS < 1)           begin : g_bad_hits  $error("MAX_HITS must be at least 1");    end
   if (ADDR_W <= $clog2(WORD)) begin : g_bad_addr  $error("ADDR_W too small for WORD");     end
   if (CW < cnt_bits(MAX_HITS)) begin : g_bad_cw   $error("CW too small for MAX_HITS");     end

   logic              win_q;
   logic              done_q;
   logic              step;
   logic [ADDR_W-1:0] word_addr;

   logic [NS-1:0]             em_vld, em_trunc;
   logic [NS-1:0][ADDR_W-1:0] em_time, em_width;

   assign step = smp_vld & win_q & ~evt_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (evt_start) begin
         win_q  <= 1'b1;
         done_q <= 1'b0;
      end else if (step && smp_last) begin
         win_q  <= 1'b0;
         done_q <= 1'b1;
      end
   end

   assign evt_done = done_q;

   hx_addr_track #(.WORD(WORD), .ADDR_W(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (evt_start),
      .base      (evt_base),
      .adv       (step),
      .word_addr (word_addr)
   );

   hx_edge_scan #(
      .WORD(WORD), .ADDR_W(ADDR_W), .MIN_W(MIN_W), .MIN_GAP(MIN_GAP)
   ) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (evt_start),
      .step      (step),
      .last      (smp_last),
      .data      (smp_data),
      .base_addr (word_addr),
      .em_vld    (em_vld),
      .em_time   (em_time),
      .em_width  (em_width),
      .em_trunc  (em_trunc)
   );

   hx_hit_store #(
      .NS(NS), .ADDR_W(ADDR_W), .MAX_HITS(MAX_HITS), .MIN_W(MIN_W),
      .IW(IW), .CW(CW)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (evt_start),
      .em_vld   (em_vld),
      .em_time  (em_time),
      .em_width (em_width),
      .em_trunc (em_trunc),
      .rd_sel   (rd_sel),
      .hit_cnt  (hit_cnt),
      .rd_time  (rd_time),
      .rd_width (rd_width),
      .rd_trunc (rd_trunc),
      .rd_idx   (rd_idx)
   );

   // R8: done only rises on the final word of an open window
   a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_done) |-> $past(smp_vld && smp_last && win_q));

   // R8: done and count hold while no new window starts
   a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_done && !evt_start) |=> (evt_done && $stable(hit_cnt)));

   // R9: a window start clears results
   a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      evt_start |=> (!evt_done && (hit_cnt == '0)));

   // R9: words outside a window leave the count alone
   a_r9_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_q && !evt_start) |=> $stable(hit_cnt));

endmodule

// File: tb/hx_pulse_extract_test.sv
`timescale 1ns/1ps
module hx_pulse_extract_test;

   localparam int AW = 12;
   localparam int WD = 8;
   localparam int MW = 4;
   localparam int MG = 4;
   localparam int MH = 7;
   localparam int IW = 3;
   localparam int CW = 3;
   localparam int RING = 1 << AW;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   logic          rst_n;
   logic          evt_start;
   logic [AW-1:0] evt_base;
   logic          smp_vld, smp_last;
   logic [WD-1:0] smp_data;
   logic [IW-1:0] rd_sel;
   logic [AW-1:0] rd_time, rd_width;
   logic          rd_trunc;
   logic [IW-1:0] rd_idx;
   logic [CW-1:0] hit_cnt;
   logic          evt_done;

   hx_pulse_extract #(
      .WORD(WD), .ADDR_W(AW), .MIN_W(MW), .MIN_GAP(MG), .MAX_HITS(MH)
   ) uut (
      .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_base(evt_base),
      .smp_vld(smp_vld), .smp_last(smp_last), .smp_data(smp_data),
      .rd_sel(rd_sel), .rd_time(rd_time), .rd_width(rd_width),
      .rd_trunc(rd_trunc), .rd_idx(rd_idx), .hit_cnt(hit_cnt),
      .evt_done(evt_done)
   );

   int vecs = 0;
   int bad  = 0;
   int cyc  = 0;
   bit exp_done = 1'b0;
   bit sb[$];
   int er[$], ew[$], etr[$];

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end

   task automatic chk(string tag, string what, int act, int exp);
      vecs++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // One clock: compare done against the model, then drive
   task automatic clk_check();
      @(negedge clk);
      chk("R8", "evt_done per clock", int'(evt_done), int'(exp_done));
   endtask

   task automatic lo(int n); for (int i = 0; i < n; i++) sb.push_back(1'b0); endtask
   task automatic hi(int n); for (int i = 0; i < n; i++) sb.push_back(1'b1); endtask
   task automatic pad(); while (sb.size() % WD != 0) sb.push_back(1'b0); endtask

   task automatic add_hit(int r, int f, int tr);
      if ((f - r) >= MW && er.size() < MH) begin
         er.push_back(r);
         ew.push_back(f - r);
         etr.push_back(tr);
      end
   endtask

   // Group high runs over the whole event and apply the rules
   task automatic model(int base);
      int  n, cr, cf;
      bit  open;
      er.delete(); ew.delete(); etr.delete();
      n = sb.size(); cr = 0; cf = 0; open = 1'b0;
      for (int i = 0; i < n; i++) begin
         bit prev;
         prev = (i == 0) ? 1'b0 : sb[i-1];
         if (sb[i] && !prev) begin
            if (!(open && (i - cf) < MG)) begin
               if (open) add_hit(cr, cf, 0);
               cr = i;
               open = 1'b1;
            end
         end
         if (!sb[i] && prev) cf = i;
      end
      if (open) begin
         if (sb[n-1]) add_hit(cr, n, 1);
         else         add_hit(cr, cf, 0);
      end
      for (int j = 0; j < er.size(); j++) er[j] = (er[j] + base) % RING;
   endtask

   task automatic run_event(int base, string tag);
      int nw;
      model(base);
      nw = sb.size() / WD;
      clk_check();
      evt_start = 1'b1; evt_base = AW'(base); smp_vld = 1'b0; smp_last = 1'b0;
      exp_done = 1'b0;
      for (int k = 0; k < nw; k++) begin
         clk_check();
         evt_start = 1'b0;
         smp_vld   = 1'b1;
         smp_last  = (k == nw - 1);
         for (int b = 0; b < WD; b++) smp_data[b] = sb[k*WD + b];
         if (k == nw - 1) exp_done = 1'b1;
      end
      clk_check();
      smp_vld = 1'b0; smp_last = 1'b0; smp_data = '0;
      chk(tag, "hit_cnt at done", int'(hit_cnt), er.size());
      for (int j = 0; j < er.size(); j++) begin
         rd_sel = IW'(j);
         #1;
         chk(tag, $sformatf("rec%0d time", j),  int'(rd_time),  er[j]);
         chk(tag, $sformatf("rec%0d width", j), int'(rd_width), ew[j]);
         chk(tag, $sformatf("rec%0d trunc", j), int'(rd_trunc), etr[j]);
         chk("R10", $sformatf("rec%0d index", j), int'(rd_idx), j);
      end
      sb.delete();
   endtask

   initial begin
      int keep_cnt, keep_t;
      rst_n = 1'b0; evt_start = 1'b0; evt_base = '0;
      smp_vld = 1'b0; smp_last = 1'b0; smp_data = '0; rd_sel = '0;
      repeat (3) @(negedge clk);
      chk("R12", "reset done", int'(evt_done), 0);
      chk("R12", "reset count", int'(hit_cnt), 0);
      rst_n = 1'b1;

      // R1 R2 R3: pulse crossing a word boundary
      lo(3); hi(7); lo(6); run_event(100, "R1");
      // R3: high in the first bin of the window
      hi(5); lo(11); run_event(0, "R3");
      // R4: a 3-bin pulse is dropped, a 5-bin pulse kept
      lo(2); hi(3); lo(6); hi(5); lo(8); run_event(200, "R4");
      // R5: gap 3 joins, gaps 5 and 4 separate
      hi(4); lo(3); hi(2); lo(5); hi(4); lo(4); hi(4); lo(6); run_event(300, "R5");
      // R5: isolated spikes joined into an accepted hit; lone spike pair dropped
      lo(1); hi(1); lo(2); hi(1); lo(2); hi(1); lo(8); hi(2); lo(8); pad(); run_event(400, "R5");
      // R6: nine qualified pulses, only seven kept
      for (int p = 0; p < 9; p++) begin hi(4); lo(4); end
      run_event(500, "R6");
      // R7: pulse still high at the window end
      lo(4); hi(12); run_event(600, "R7");
      // R7: candidate in its closing gap at the window end
      hi(5); lo(3); run_event(700, "R7");
      // R11: pulse crossing address zero
      lo(2); hi(6); lo(8); run_event(RING - 8, "R11");
      // R2: long pulse spanning several words
      lo(7); hi(21); lo(4); run_event(1000, "R2");

      // R9: words outside a window are ignored
      keep_cnt = int'(hit_cnt);
      rd_sel = '0; #1; keep_t = int'(rd_time);
      for (int k = 0; k < 3; k++) begin
         clk_check();
         smp_vld = 1'b1; smp_last = 1'b1; smp_data = '1;
      end
      clk_check();
      smp_vld = 1'b0; smp_last = 1'b0; smp_data = '0;
      chk("R9", "count after stray words", int'(hit_cnt), keep_cnt);
      rd_sel = '0; #1;
      chk("R9", "record after stray words", int'(rd_time), keep_t);

      // R9: a new window clears the previous results
      lo(16); run_event(1100, "R9");

      repeat (2) clk_check();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

endmodule